// File: doc/BRIEF.md
# Dual-byte-strobe DRAM cycle decoder

This block is the device-side control logic of a 16-bit asynchronous DRAM model. A free-running clock samples the row strobe, the two byte column strobes, write enable, output enable, the multiplexed address and the write data. From the sampled pins it latches a row and a column and classifies every memory cycle. It also drives per-byte write strobes into a small behavioural word array and per-byte output enables towards the data pins.

The two byte strobes are merged into one internal column strobe. The merged strobe turns active when the first byte strobe falls and turns inactive only when both strobes have returned high. When a column strobe is already low at the moment the row strobe falls, the cycle is a refresh. That refresh takes its row from an internal counter and never touches data. Every other row-strobe cycle names its row on the address pins, and that row is reported as refreshed as well. Read data and output enables are registered, and the array is written so that block RAM can be inferred.

Top module: `dram_cycle_decoder`

## Requirements
- R1: The row address is captured from `addr` in the sample where `ras_n` is first seen low, unless that cycle is a refresh (R5).
- R2: The column address is captured from `addr` when the merged column strobe falls while the row strobe is low. Later column-strobe pulses in the same row-strobe low period (page mode) capture new columns against the same row.
- R3: The merged column strobe falls with the first of `lcas_n`/`ucas_n` and rises only once both are high. Address changes while either strobe is still low capture no new column.
- R4: `dout_oe[0]` (bits 7:0) is 1 only while `lcas_n` is low, and `dout_oe[1]` (bits 15:8) only while `ucas_n` is low. Each also needs `oe_n` low, `we_n` high and an open read access. `dout` then carries the addressed word.
- R5: If the merged column strobe is low when `ras_n` falls, `cyc_kind` becomes 5 (refresh). `refresh_row` takes the 9-bit counter value, the address pins are ignored, and the counter then increments, starting from 0 after reset. `dout_oe` stays 0 throughout.
- R6: If `we_n` is low when the merged column strobe falls, `cyc_kind` becomes 3 (early write). The word on `din` is written, and `dout_oe` stays 0.
- R7: If `we_n` falls while a read access (`cyc_kind` 2) holds the column strobe low, `cyc_kind` becomes 4 (late write). The `din` sampled at that `we_n` fall is written to the current row and column, and later changes of `din` have no effect.
- R8: A write updates only the byte lanes whose strobe is low at the write edge. Bit 0 of the lane mask is `lcas_n`, bit 1 is `ucas_n`. The other byte keeps its value.
- R9: A row-strobe cycle with a supplied row sets `cyc_kind` to 1 (row open) and reports that row on `refresh_row`. The refresh counter is left unchanged.
- R10: With `ras_n` and both column strobes high, `dout_oe` is 0. Setting `oe_n` high during a read also clears `dout_oe`.
- R11: After reset, `cyc_kind` is 0 (idle), `dout_oe` is 0 and `refresh_row` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Column strobe for bits 7:0, active low |
| ucas_n | input | 1 | Column strobe for bits 15:8, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row/column address |
| din | input | 16 | Write data |
| dout | output | 16 | Read data of the addressed word |
| dout_oe | output | 2 | Per-byte output enable (bit 0 low byte) |
| cyc_kind | output | 3 | Cycle class: 0 idle, 1 row open, 2 read, 3 early write, 4 late write, 5 refresh |
| refresh_row | output | 9 | Row most recently refreshed |

## Verification
A pin change is registered on the next clock edge, and the edge detection and classification act one edge later. So `cyc_kind` and `refresh_row` are due two edges after the stimulus, `dout_oe` is due three edges after it, and `dout` after a write is due four edges after it. The driver holds the pins for two cycles and then queues its expected item with a due time three cycles later. The monitor compares each item only once that time has passed, and the pins stay unchanged until the comparison is done. Each checked edge order is set up in separate steps: strobe-before-row-strobe, write-enable-before and after column strobe, and staggered byte strobes.

// File: rtl/dramdec_pkg.sv
package dramdec_pkg;
  typedef enum logic [2:0] {
    KIND_IDLE    = 3'd0,
    KIND_ROWOPEN = 3'd1,
    KIND_READ    = 3'd2,
    KIND_EARLYWR = 3'd3,
    KIND_LATEWR  = 3'd4,
    KIND_REFRESH = 3'd5
  } kind_e;
endpackage

// File: rtl/dramdec_sampler.sv
module dramdec_sampler #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              lcas_n,
  input  logic              ucas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              s_ras_n,
  output logic [1:0]        s_cas_n,
  output logic              s_we_n,
  output logic              s_oe_n,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_din,
  output logic              cas_n,
  output logic              ras_fall,
  output logic              cas_fall,
  output logic              we_fall
);
  logic p_ras_n, p_cas_n, p_we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ras_n <= 1'b1;
      s_cas_n <= 2'b11;
      s_we_n  <= 1'b1;
      s_oe_n  <= 1'b1;
      s_addr  <= '0;
      s_din   <= '0;
      p_ras_n <= 1'b1;
      p_cas_n <= 1'b1;
      p_we_n  <= 1'b1;
    end else begin
      s_ras_n <= ras_n;
      s_cas_n <= {ucas_n, lcas_n};
      s_we_n  <= we_n;
      s_oe_n  <= oe_n;
      s_addr  <= addr;
      s_din   <= din;
      p_ras_n <= s_ras_n;
      p_cas_n <= cas_n;
      p_we_n  <= s_we_n;
    end
  end

  // merged strobe: low while any byte strobe is low
  assign cas_n    = &s_cas_n;
  assign ras_fall = p_ras_n & ~s_ras_n;
  assign cas_fall = p_cas_n & ~cas_n;
  assign we_fall  = p_we_n & ~s_we_n;
endmodule

// File: rtl/dramdec_ctrl.sv
module dramdec_ctrl
  import dramdec_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 16,
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  localparam int AW      = ROW_BITS + COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_ras_n,
  input  logic [1:0]        s_cas_n,
  input  logic              s_we_n,
  input  logic              s_oe_n,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_din,
  input  logic              cas_n,
  input  logic              ras_fall,
  input  logic              cas_fall,
  input  logic              we_fall,
  output logic [AW-1:0]     rd_addr,
  output logic              wr_en,
  output logic [1:0]        wr_be,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [1:0]        dout_oe,
  output kind_e             kind,
  output logic [ADDR_W-1:0] refresh_row
);
  logic [ADDR_W-1:0] row_q, col_q, rcnt;
  logic              acc_q;
  logic              open_row;

  assign open_row = ~s_ras_n && (kind != KIND_REFRESH) && (kind != KIND_IDLE);
  assign rd_addr  = {row_q[ROW_BITS-1:0], col_q[COL_BITS-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      kind        <= KIND_IDLE;
      row_q       <= '0;
      col_q       <= '0;
      rcnt        <= '0;
      refresh_row <= '0;
      acc_q       <= 1'b0;
      wr_en       <= 1'b0;
      wr_be       <= 2'b00;
      wr_addr     <= '0;
      wr_data     <= '0;
      dout_oe     <= 2'b00;
    end else begin
      wr_en   <= 1'b0;
      wr_be   <= ~s_cas_n;
      wr_data <= s_din;
      for (int i = 0; i < 2; i++)
        dout_oe[i] <= acc_q & ~s_cas_n[i] & ~s_oe_n & s_we_n;
      if (cas_n) acc_q <= 1'b0;
      if (ras_fall) begin
        acc_q <= 1'b0;
        if (!cas_n) begin
          kind        <= KIND_REFRESH;
          refresh_row <= rcnt;
          rcnt        <= rcnt + 1'b1;
        end else begin
          kind        <= KIND_ROWOPEN;
          row_q       <= s_addr;
          refresh_row <= s_addr;
        end
      end else if (open_row) begin
        if (cas_fall) begin
          col_q <= s_addr;
          acc_q <= 1'b1;
          if (!s_we_n) begin
            kind    <= KIND_EARLYWR;
            wr_en   <= 1'b1;
            wr_addr <= {row_q[ROW_BITS-1:0], s_addr[COL_BITS-1:0]};
          end else begin
            kind <= KIND_READ;
          end
        end else if (we_fall && !cas_n && kind == KIND_READ) begin
          kind    <= KIND_LATEWR;
          wr_en   <= 1'b1;
          wr_addr <= rd_addr;
        end
      end
    end
  end

  AST_CBR_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (ras_fall && !cas_n) |=> (rcnt == $past(rcnt) + 1'b1)); // R5
  AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (rst)
    (kind == KIND_REFRESH && $past(kind == KIND_REFRESH)) |-> (dout_oe == 2'b00)); // R5
  AST_WRITE_HAS_LANE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_be != 2'b00)); // R8
  AST_ROWONLY_KEEPS_CNT: assert property (@(posedge clk) disable iff (rst)
    (ras_fall && cas_n) |=> (rcnt == $past(rcnt))); // R9
endmodule

// File: rtl/dramdec_array.sv
module dramdec_array #(
  parameter int AW     = 6,
  parameter int DATA_W = 16,
  localparam int LANES = 2,
  localparam int LW    = DATA_W / LANES,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_be,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) mem[wr_addr] <= wr_data[g*LW +: LW];
      rd_data[g*LW +: LW] <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dramdec_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 16,
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  localparam int AW      = ROW_BITS + COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              lcas_n,
  input  logic              ucas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [1:0]        dout_oe,
  output logic [2:0]        cyc_kind,
  output logic [ADDR_W-1:0] refresh_row
);
  logic              s_ras_n, s_we_n, s_oe_n, cas_n, ras_fall, cas_fall, we_fall;
  logic [1:0]        s_cas_n, wr_be;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_din, wr_data;
  logic [AW-1:0]     rd_addr, wr_addr;
  logic              wr_en;
  kind_e             kind;

  dramdec_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk(clk), .rst(rst), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
    .s_ras_n(s_ras_n), .s_cas_n(s_cas_n), .s_we_n(s_we_n), .s_oe_n(s_oe_n),
    .s_addr(s_addr), .s_din(s_din), .cas_n(cas_n), .ras_fall(ras_fall),
    .cas_fall(cas_fall), .we_fall(we_fall));

  dramdec_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_BITS(ROW_BITS),
                 .COL_BITS(COL_BITS)) u_ctl (
    .clk(clk), .rst(rst), .s_ras_n(s_ras_n), .s_cas_n(s_cas_n),
    .s_we_n(s_we_n), .s_oe_n(s_oe_n), .s_addr(s_addr), .s_din(s_din),
    .cas_n(cas_n), .ras_fall(ras_fall), .cas_fall(cas_fall), .we_fall(we_fall),
    .rd_addr(rd_addr), .wr_en(wr_en), .wr_be(wr_be), .wr_addr(wr_addr),
    .wr_data(wr_data), .dout_oe(dout_oe), .kind(kind),
    .refresh_row(refresh_row));

  dramdec_array #(.AW(AW), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .wr_en(wr_en), .wr_be(wr_be), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(dout));

  assign cyc_kind = kind;

  AST_MERGED_FIRST_FALL: assert property (@(posedge clk) disable iff (rst)
    cas_fall |-> ($past(lcas_n && ucas_n, 2) && !$past(lcas_n && ucas_n, 1))); // R3
  AST_LOW_LANE_STROBE: assert property (@(posedge clk) disable iff (rst)
    dout_oe[0] |-> !$past(lcas_n, 2)); // R4
  AST_HIGH_LANE_STROBE: assert property (@(posedge clk) disable iff (rst)
    dout_oe[1] |-> !$past(ucas_n, 2)); // R4
  AST_NO_WRITE_IN_REFRESH: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (kind == KIND_EARLYWR || kind == KIND_LATEWR)); // R6
endmodule

// File: tb/dram_cycle_decoder_test.sv
module dram_cycle_decoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_n = 1, lcas_n = 1, ucas_n = 1, we_n = 1, oe_n = 1;
  logic [8:0]  addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  dout_oe;
  logic [2:0]  cyc_kind;
  logic [8:0]  refresh_row;

  always #5 clk = ~clk;

  dram_cycle_decoder uut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout),
    .dout_oe(dout_oe), .cyc_kind(cyc_kind), .refresh_row(refresh_row));

  typedef struct {
    string       tag;
    int          due;
    logic [2:0]  kind;
    logic [1:0]  oe;
    logic        chk_d;
    logic [15:0] d;
    logic        chk_r;
    logic [8:0]  r;
  } item_t;

  item_t q[$];
  int cyc = 0, n_cmp = 0, n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares each queued item once its due cycle has passed
  always @(negedge clk) begin
    if (q.size() > 0 && cyc >= q[0].due) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (cyc_kind !== it.kind || dout_oe !== it.oe ||
          (it.chk_d && dout !== it.d) || (it.chk_r && refresh_row !== it.r)) begin
        n_bad++;
        $display("FAIL %s: kind=%0d oe=%b dout=%h row=%h expected kind=%0d oe=%b dout=%h row=%h",
                 it.tag, cyc_kind, dout_oe, dout, refresh_row,
                 it.kind, it.oe, it.d, it.r);
      end
    end
  end

  task automatic pins(input logic r, input logic l, input logic u, input logic w,
                      input logic o, input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    ras_n = r; lcas_n = l; ucas_n = u; we_n = w; oe_n = o; addr = a; din = d;
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_item(input string tag, input logic [2:0] k, input logic [1:0] o,
                             input logic cd, input logic [15:0] d,
                             input logic cr, input logic [8:0] r);
    item_t it;
    it.tag = tag; it.due = cyc + 3; it.kind = k; it.oe = o;
    it.chk_d = cd; it.d = d; it.chk_r = cr; it.r = r;
    q.push_back(it);
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2ms;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_item("R11 reset state", 3'd0, 2'b00, 0, 0, 1, 9'd0);

    // early word write row 2 col 5
    pins(0, 1, 1, 1, 1, 9'd2, 16'h0);
    expect_item("R1 R9 row open", 3'd1, 2'b00, 0, 0, 1, 9'd2);
    pins(0, 1, 1, 0, 0, 9'd5, 16'hA1B2);
    pins(0, 0, 0, 0, 0, 9'd5, 16'hA1B2);
    expect_item("R6 early write quiet", 3'd3, 2'b00, 0, 0, 1, 9'd2);
    pins(0, 1, 1, 1, 0, 9'd5, 16'h0);
    pins(1, 1, 1, 1, 0, 9'd5, 16'h0);

    // read, page-mode write, page-mode read
    pins(0, 1, 1, 1, 0, 9'd2, 16'h0);
    pins(0, 0, 0, 1, 0, 9'd5, 16'h0);
    expect_item("R2 R4 word read", 3'd2, 2'b11, 1, 16'hA1B2, 0, 0);
    pins(0, 1, 1, 0, 0, 9'd6, 16'h1234);
    pins(0, 0, 0, 0, 0, 9'd6, 16'h1234);
    expect_item("R6 page early write", 3'd3, 2'b00, 0, 0, 0, 0);
    pins(0, 1, 1, 1, 0, 9'd5, 16'h0);
    pins(0, 0, 0, 1, 0, 9'd5, 16'h0);
    expect_item("R2 page read same row", 3'd2, 2'b11, 1, 16'hA1B2, 0, 0);
    pins(0, 0, 0, 1, 1, 9'd5, 16'h0);
    expect_item("R10 oe high clears", 3'd2, 2'b00, 0, 0, 0, 0);
    pins(0, 1, 1, 1, 0, 9'd5, 16'h0);
    pins(1, 1, 1, 1, 0, 9'd5, 16'h0);
    expect_item("R10 strobes high", 3'd2, 2'b00, 0, 0, 0, 0);

    // byte writes
    pins(0, 1, 1, 1, 0, 9'd2, 16'h0);
    pins(0, 1, 1, 0, 0, 9'd5, 16'hFFEE);
    pins(0, 0, 1, 0, 0, 9'd5, 16'hFFEE);
    pins(0, 1, 1, 0, 0, 9'd5, 16'h7700);
    pins(0, 1, 0, 0, 0, 9'd5, 16'h7700);
    pins(0, 1, 1, 1, 0, 9'd5, 16'h0);
    pins(0, 0, 0, 1, 0, 9'd5, 16'h0);
    expect_item("R8 byte lanes merged", 3'd2, 2'b11, 1, 16'h77EE, 0, 0);
    pins(0, 1, 1, 1, 0, 9'd5, 16'h0);
    pins(0, 1, 0, 1, 0, 9'd5, 16'h0);
    expect_item("R4 upper only enable", 3'd2, 2'b10, 1, 16'h77EE, 0, 0);
    pins(0, 1, 1, 1, 0, 9'd5, 16'h0);

    // merged strobe ordering
    pins(0, 0, 1, 1, 0, 9'd5, 16'h0);
    expect_item("R3 R4 lower first", 3'd2, 2'b01, 1, 16'h77EE, 0, 0);
    pins(0, 0, 0, 1, 0, 9'd6, 16'h0);
    expect_item("R3 second strobe no relatch", 3'd2, 2'b11, 1, 16'h77EE, 0, 0);
    pins(0, 1, 0, 1, 0, 9'd6, 16'h0);
    expect_item("R3 held by last strobe", 3'd2, 2'b10, 1, 16'h77EE, 0, 0);
    pins(0, 1, 1, 1, 0, 9'd6, 16'h0);
    pins(0, 0, 1, 1, 0, 9'd6, 16'h0);
    expect_item("R3 relatch after both high", 3'd2, 2'b01, 1, 16'h1234, 0, 0);
    pins(0, 1, 1, 1, 0, 9'd6, 16'h0);
    pins(1, 1, 1, 1, 0, 9'd6, 16'h0);

    // late write row 3 col 1
    pins(0, 1, 1, 1, 0, 9'd3, 16'h0);
    pins(0, 0, 0, 1, 0, 9'd1, 16'h0);
    expect_item("R7 read before late write", 3'd2, 2'b11, 0, 0, 0, 0);
    pins(0, 0, 0, 1, 1, 9'd1, 16'h5A5A);
    pins(0, 0, 0, 0, 1, 9'd1, 16'h5A5A);
    expect_item("R7 late write", 3'd4, 2'b00, 0, 0, 0, 0);
    pins(0, 0, 0, 0, 1, 9'd1, 16'h0000);
    pins(0, 1, 1, 1, 0, 9'd1, 16'h0);
    pins(1, 1, 1, 1, 0, 9'd1, 16'h0);
    pins(0, 1, 1, 1, 0, 9'd3, 16'h0);
    pins(0, 0, 0, 1, 0, 9'd1, 16'h0);
    expect_item("R7 data from we fall", 3'd2, 2'b11, 1, 16'h5A5A, 0, 0);
    pins(0, 1, 1, 1, 0, 9'd1, 16'h0);
    pins(1, 1, 1, 1, 0, 9'd1, 16'h0);

    // refresh cycles
    pins(1, 0, 0, 1, 0, 9'h1FF, 16'h0);
    pins(0, 0, 0, 1, 0, 9'h1FF, 16'h0);
    expect_item("R5 first counter refresh", 3'd5, 2'b00, 0, 0, 1, 9'd0);
    pins(1, 1, 1, 1, 0, 9'h1FF, 16'h0);
    pins(1, 0, 1, 1, 0, 9'h155, 16'h0);
    pins(0, 0, 1, 1, 0, 9'h155, 16'h0);
    expect_item("R5 counter increments", 3'd5, 2'b00, 0, 0, 1, 9'd1);
    pins(1, 1, 1, 1, 0, 9'h155, 16'h0);
    pins(0, 1, 1, 1, 0, 9'h0A5, 16'h0);
    expect_item("R9 row-only refresh", 3'd1, 2'b00, 0, 0, 1, 9'h0A5);
    pins(1, 1, 1, 1, 0, 9'h0A5, 16'h0);
    pins(1, 1, 0, 1, 0, 9'h0A5, 16'h0);
    pins(0, 1, 0, 1, 0, 9'h0A5, 16'h0);
    expect_item("R5 counter unaffected by row-only", 3'd5, 2'b00, 0, 0, 1, 9'd2);
    pins(1, 1, 1, 1, 0, 9'h0A5, 16'h0);

    // data kept across refresh
    pins(0, 1, 1, 1, 0, 9'd2, 16'h0);
    pins(0, 0, 0, 1, 0, 9'd5, 16'h0);
    expect_item("R1 R5 data kept", 3'd2, 2'b11, 1, 16'h77EE, 1, 9'd2);
    pins(1, 1, 1, 1, 0, 9'd5, 16'h0);

    repeat (4) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule